// File: doc/BRIEF.md
# Tagged Entry Word Packer

This block joins a 32-bit host data port to two queues of 16-bit tagged entries. Each entry pairs an 8-bit tag (bits 15:8) with one data byte (bits 7:0). Host writes go into the transmit queue, which a downstream bus engine drains one entry at a time. The engine fills the receive queue one entry at a time, and host reads drain it.

Two separate mode inputs decide how a 32-bit host word maps onto entries. With write packing on, one host write carries two entries. With read unpacking on, one host read returns up to two entries. With a mode off, a host word carries a single entry in its low half. Both queues report their occupancy in entries. The receive side also gives a not-empty flag, which software tests before each read.

Every byte travels with its tag, so each queue holds half as many data bytes as its raw byte size. Writes that do not fit are dropped whole, and a sticky overflow flag records that this happened.

Top module: `tagged_entry_packer`

## Requirements
- R1: Entries keep their 16-bit layout from end to end: the tag is in bits 15:8 and the data byte in bits 7:0. An entry leaves `out_entry`, or arrives in `host_rdata`, exactly as it was written or pushed.
- R2: With `mode_pack` high, a host write enqueues two entries. Bits 15:0 enter the transmit queue first and bits 31:16 enter second.
- R3: With `mode_pack` low, a host write enqueues only bits 15:0 as one entry, and bits 31:16 are ignored.
- R4: With `mode_unpack` high and at least two entries queued, a host read consumes two entries. The older entry appears in bits 15:0 (its data byte in 7:0) and the newer one in bits 31:16 (its data byte in 23:16).
- R5: With `mode_unpack` low, a host read consumes one entry, returned in bits 15:0 with bits 31:16 zero.
- R6: With `mode_unpack` high and exactly one entry queued, a host read returns that entry in bits 15:0 with bits 31:16 zero, and consumes only that entry.
- R7: A host read while the receive queue is empty returns zero and consumes nothing. `host_rdata` updates one cycle after `host_rd` and otherwise holds its value.
- R8: A host write that needs more free slots than remain (two slots when packing, one otherwise) is dropped whole. It sets `wr_overflow`, which then stays high until reset. Free slots are counted before any pop in the same cycle.
- R9: `out_count` and `in_count` give the current occupancy in entries. They change one cycle after the operations that cause the change. `in_not_empty` and `out_valid` are high exactly when the matching count is non-zero.
- R10: Each queue holds RAW_BYTES/2 entries, so it holds RAW_BYTES/2 data bytes. An `in_push` while the receive queue is full is dropped.
- R11: After reset both queues are empty, `host_rdata` is zero and `wr_overflow` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_pack | input | 1 | Write packing: two entries per host write |
| mode_unpack | input | 1 | Read unpacking: up to two entries per host read |
| host_wr | input | 1 | Host write strobe |
| host_wdata | input | 32 | Host write word |
| host_rd | input | 1 | Host read strobe |
| host_rdata | output | 32 | Host read word, registered |
| out_pop | input | 1 | Engine takes the head transmit entry |
| out_entry | output | 16 | Head transmit entry |
| out_valid | output | 1 | Transmit queue not empty |
| out_count | output | $clog2(RAW_BYTES/2+1) | Transmit occupancy in entries |
| in_push | input | 1 | Engine delivers a received entry |
| in_entry | input | 16 | Received entry |
| in_count | output | $clog2(RAW_BYTES/2+1) | Receive occupancy in entries |
| in_not_empty | output | 1 | Receive queue holds at least one entry |
| wr_overflow | output | 1 | Sticky dropped-write flag |

## Verification
The bench drives a directed run first, then a random run, with both modes held steady in some phases and switched in others:

- **Packed writes with distinct low and high halves** tell the correct lane order apart from a swapped one.
- **Unpacked writes with a non-zero high half** show whether that half is wrongly enqueued.
- **Receive reads at occupancies of two or more, exactly one, and zero** separate the pair, single-entry and empty-read paths.
- **Filling the transmit queue to one free slot, then writing in packed mode**, shows whether a partial write slips in and whether the overflow flag latches.
- **Random interleaving of pushes, pops, reads and writes** checks that same-cycle operations combine correctly into the counts.

// File: rtl/tagged_entry_packer.sv
module tagged_entry_packer #(
  parameter int RAW_BYTES = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        mode_pack,
  input  logic        mode_unpack,
  input  logic        host_wr,
  input  logic [31:0] host_wdata,
  input  logic        host_rd,
  output logic [31:0] host_rdata,
  input  logic        out_pop,
  output logic [15:0] out_entry,
  output logic        out_valid,
  output logic [$clog2(RAW_BYTES/2+1)-1:0] out_count,
  input  logic        in_push,
  input  logic [15:0] in_entry,
  output logic [$clog2(RAW_BYTES/2+1)-1:0] in_count,
  output logic        in_not_empty,
  output logic        wr_overflow
);
  localparam int DEPTH = RAW_BYTES / 2;
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [15:0]   omem [DEPTH];
  logic [15:0]   imem [DEPTH];
  logic [AW-1:0] owp, orp, iwp, irp;
  logic [CW-1:0] ocnt, icnt;

  logic [1:0]  wr_need, wr_n, rd_n;
  logic [CW:0] ofree;
  logic        wr_ok, pop_ok, push_ok, rd_two, rd_one;

  assign wr_need = mode_pack ? 2'd2 : 2'd1;
  assign ofree   = (CW+1)'(DEPTH) - {1'b0, ocnt};
  assign wr_ok   = host_wr && (ofree >= (CW+1)'(wr_need));
  assign wr_n    = wr_ok ? wr_need : 2'd0;
  assign pop_ok  = out_pop && (ocnt != '0);
  assign push_ok = in_push && (icnt != CW'(DEPTH));
  assign rd_two  = host_rd && mode_unpack && (icnt >= CW'(2));
  assign rd_one  = host_rd && !rd_two && (icnt != '0);
  assign rd_n    = {rd_two, rd_one};

  always_ff @(posedge clk) begin
    if (wr_ok) begin
      omem[owp] <= host_wdata[15:0];
      if (mode_pack) omem[AW'(owp + 1'b1)] <= host_wdata[31:16];
    end
    if (push_ok) imem[iwp] <= in_entry;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      owp <= '0; orp <= '0; ocnt <= '0;
      iwp <= '0; irp <= '0; icnt <= '0;
      host_rdata  <= '0;
      wr_overflow <= 1'b0;
    end else begin
      owp  <= owp + AW'(wr_n);
      orp  <= orp + AW'(pop_ok);
      ocnt <= ocnt + CW'(wr_n) - CW'(pop_ok);
      iwp  <= iwp + AW'(push_ok);
      irp  <= irp + AW'(rd_n);
      icnt <= icnt + CW'(push_ok) - CW'(rd_n);
      if (host_wr && !wr_ok) wr_overflow <= 1'b1;
      if (host_rd) begin
        if (rd_two)      host_rdata <= {imem[AW'(irp + 1'b1)], imem[irp]};
        else if (rd_one) host_rdata <= {16'h0000, imem[irp]};
        else             host_rdata <= '0;
      end
    end
  end

  assign out_entry    = omem[orp];
  assign out_valid    = ocnt != '0;
  assign out_count    = ocnt;
  assign in_count     = icnt;
  assign in_not_empty = icnt != '0;

  a_r9_out_bound: assert property (@(posedge clk) disable iff (!rst_n)
    ocnt <= CW'(DEPTH));
  a_r10_in_bound: assert property (@(posedge clk) disable iff (!rst_n)
    icnt <= CW'(DEPTH));
  a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    wr_overflow |=> wr_overflow);
  a_r8_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && mode_pack && !out_pop && ocnt > CW'(DEPTH - 2)) |=> ($stable(ocnt) && wr_overflow));
  a_r7_empty_read: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && icnt == '0) |=> (host_rdata == 32'h0));
  a_r6_single: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && mode_unpack && icnt == CW'(1) && !in_push) |=> (icnt == '0 && host_rdata[31:16] == 16'h0));
endmodule

// File: tb/tagged_entry_packer_tb_top.sv
module tagged_entry_packer_tb_top;
  localparam int RAW = 32;
  localparam int DEPTH = RAW / 2;
  localparam int CW = $clog2(DEPTH + 1);

  logic clk = 1'b0, rst_n = 1'b0;
  logic mode_pack = 1'b0, mode_unpack = 1'b0;
  logic host_wr = 1'b0, host_rd = 1'b0, out_pop = 1'b0, in_push = 1'b0;
  logic [31:0] host_wdata = '0;
  logic [15:0] in_entry = '0;
  logic [31:0] host_rdata;
  logic [15:0] out_entry;
  logic out_valid, in_not_empty, wr_overflow;
  logic [CW-1:0] out_count, in_count;

  always #4 clk = ~clk;

  tagged_entry_packer #(.RAW_BYTES(RAW)) dut_i (
    .clk(clk), .rst_n(rst_n), .mode_pack(mode_pack), .mode_unpack(mode_unpack),
    .host_wr(host_wr), .host_wdata(host_wdata), .host_rd(host_rd), .host_rdata(host_rdata),
    .out_pop(out_pop), .out_entry(out_entry), .out_valid(out_valid), .out_count(out_count),
    .in_push(in_push), .in_entry(in_entry), .in_count(in_count),
    .in_not_empty(in_not_empty), .wr_overflow(wr_overflow));

  int tests = 0, fails = 0;
  logic [15:0] oq[$];
  logic [15:0] iq[$];
  logic        m_ovf = 1'b0;
  logic [31:0] m_rd = '0;
  bit          done = 1'b0;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // reference model, updated on every rising edge
  always @(posedge clk) begin
    if (!rst_n) begin
      oq.delete(); iq.delete(); m_ovf = 1'b0; m_rd = '0;
    end else begin
      int opre, ipre, need;
      opre = oq.size(); ipre = iq.size();
      need = mode_pack ? 2 : 1;
      if (out_pop && opre > 0) void'(oq.pop_front());
      if (host_wr) begin
        if (DEPTH - opre >= need) begin
          oq.push_back(host_wdata[15:0]);
          if (mode_pack) oq.push_back(host_wdata[31:16]);
        end else m_ovf = 1'b1;
      end
      if (host_rd) begin
        if (mode_unpack && ipre >= 2) begin
          m_rd = {iq[1], iq[0]};
          void'(iq.pop_front()); void'(iq.pop_front());
        end else if (ipre >= 1) begin
          m_rd = {16'h0000, iq[0]};
          void'(iq.pop_front());
        end else m_rd = '0;
      end
      if (in_push && ipre < DEPTH) iq.push_back(in_entry);
    end
  end

  // compare on every falling edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R9 out_count", 32'(out_count), 32'(oq.size()));
      chk("R9 in_count", 32'(in_count), 32'(iq.size()));
      chk("R9 in_not_empty", 32'(in_not_empty), 32'(iq.size() != 0));
      chk("R9 out_valid", 32'(out_valid), 32'(oq.size() != 0));
      if (oq.size() != 0) chk("R1/R2/R3 out_entry", 32'(out_entry), 32'(oq[0]));
      chk("R4/R5/R6/R7 host_rdata", host_rdata, m_rd);
      chk("R8 wr_overflow", 32'(wr_overflow), 32'(m_ovf));
    end
  end

  task automatic idle();
    host_wr = 0; host_rd = 0; out_pop = 0; in_push = 0;
  endtask

  task automatic hwrite(logic [31:0] w);
    @(negedge clk); idle(); host_wr = 1; host_wdata = w;
  endtask

  task automatic push(logic [15:0] e);
    @(negedge clk); idle(); in_push = 1; in_entry = e;
  endtask

  task automatic hread();
    @(negedge clk); idle(); host_rd = 1;
  endtask

  task automatic pop();
    @(negedge clk); idle(); out_pop = 1;
  endtask

  task automatic settle();
    @(negedge clk); idle();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11: reset state
    chk("R11 out_count", 32'(out_count), 0);
    chk("R11 in_count", 32'(in_count), 0);
    chk("R11 host_rdata", host_rdata, 0);
    chk("R11 wr_overflow", 32'(wr_overflow), 0);

    // R2: packed lane order
    mode_pack = 1;
    hwrite(32'hA2B3_0155);
    settle();
    chk("R2 first entry low half", 32'(out_entry), 32'h0155);
    pop(); settle();
    chk("R2 second entry high half", 32'(out_entry), 32'hA2B3);
    pop(); settle();

    // R3: unpacked write ignores upper half
    mode_pack = 0;
    hwrite(32'hFFFF_0277);
    settle();
    chk("R3 one entry", 32'(out_count), 1);
    chk("R3 entry value", 32'(out_entry), 32'h0277);
    pop(); settle();

    // R10/R8: fill to capacity then overflow
    mode_pack = 1;
    for (int k = 0; k < DEPTH/2; k++) hwrite({8'h02, 8'(2*k+1), 8'h02, 8'(2*k)});
    settle();
    chk("R10 full capacity", 32'(out_count), DEPTH);
    pop(); settle();
    hwrite(32'h0303_0404);
    settle();
    chk("R8 partial write dropped", 32'(out_count), DEPTH - 1);
    chk("R8 overflow set", 32'(wr_overflow), 1);
    mode_pack = 0;
    hwrite(32'h0000_0499);
    settle();
    chk("R8 single fits", 32'(out_count), DEPTH);
    for (int k = 0; k < DEPTH; k++) pop();
    settle();
    chk("R8 overflow sticky", 32'(wr_overflow), 1);

    // R4/R6/R7: unpacked reads, even, odd, empty
    mode_unpack = 1;
    push(16'h0511); push(16'h0622); push(16'h0733);
    hread(); settle();
    chk("R4 pair", host_rdata, 32'h0622_0511);
    hread(); settle();
    chk("R6 single", host_rdata, 32'h0000_0733);
    chk("R6 consumed one", 32'(in_count), 0);
    hread(); settle();
    chk("R7 empty read", host_rdata, 0);

    // R5: one entry per read
    mode_unpack = 0;
    push(16'h0844); push(16'h0955);
    hread(); settle();
    chk("R5 single entry", host_rdata, 32'h0000_0844);
    chk("R5 left one", 32'(in_count), 1);
    hread(); settle();

    // R10: push into full receive queue dropped
    for (int k = 0; k < DEPTH + 2; k++) push(16'(16'h0A00 + k));
    settle();
    chk("R10 receive full", 32'(in_count), DEPTH);
    for (int k = 0; k < DEPTH; k++) hread();
    settle();

    // random mix
    for (int k = 0; k < 4000; k++) begin
      @(negedge clk);
      host_wr = ($urandom_range(0, 3) == 0);
      host_rd = ($urandom_range(0, 3) == 0);
      out_pop = ($urandom_range(0, 2) == 0);
      in_push = ($urandom_range(0, 2) != 0);
      host_wdata = $urandom;
      in_entry = 16'($urandom);
      if ($urandom_range(0, 31) == 0) mode_pack = ~mode_pack;
      if ($urandom_range(0, 31) == 0) mode_unpack = ~mode_unpack;
    end
    settle(); settle();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      tests++; fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule